// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block collects per-channel event pulses from a multi-channel DMA engine and turns them into interrupt state. Four event classes are tracked independently: transfer done, source-side error, destination-side error and configuration error. Each class keeps a sticky raw vector with one bit per channel. A masked view of that vector is ANDed with each channel's interrupt enables. One interrupt line is raised while any masked bit in any class is set.

Software reaches the state through a small register port. It reads the masked views, the raw vectors and a channel-busy vector. It acknowledges events by writing ones to a raw vector, and only the bits written as one are cleared. Each channel supplies two enable bits taken from its control word. The low bit of the pair gates the done class. The high bit gates the three error classes.

The register port is run by a two-state machine. `PORT_IDLE` means no read data is valid. `PORT_RESP` means read data is valid on the outputs.
- `PORT_IDLE` goes to `PORT_RESP` on a read strobe.
- `PORT_RESP` stays in `PORT_RESP` when another read strobe arrives (back-to-back reads).
- `PORT_RESP` returns to `PORT_IDLE` when no read strobe arrives.

Writes are accepted in either state.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) all raw bits are zero, irq is low and bus_rvalid is low.
- R2: An event pulse on channel i of a class sets raw bit i of that class at the next clock edge. The bit then stays set until it is cleared.
- R3: A write to a raw register clears bit i of that class wherever the write data has a 1 in bit i. Bits written as 0 are unchanged. Writing all ones clears the whole class. The raw registers sit at 0x810 (done), 0x814 (source error), 0x818 (destination error) and 0x81C (configuration error).
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after that edge.
- R5: The masked registers sit at 0x800 (done), 0x804 (source error), 0x808 (destination error) and 0x80C (configuration error). Bit i of a masked register is raw bit i ANDed with that channel's enable. The done class uses ch_ie[2i]. The three error classes use ch_ie[2i+1].
- R6: irq is the OR of all masked bits of all four classes. It follows an enable change in the same cycle, with no clock edge in between.
- R7: A read of 0x820 returns the ch_busy vector present in the cycle of the read strobe.
- R8: A read strobe produces bus_rvalid high and the read data in the cycle after its clock edge. bus_rvalid is low in any cycle not preceded by a read strobe. Data bits above the channel count, and any offset not listed here, read as zero.
- R9: Writes to the masked registers, the busy register or unlisted offsets change no raw bit.
- R10: Back-to-back read strobes each return their own data one cycle later, with bus_rvalid held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| ev_done | input | NCH | Per-channel transfer-done pulses |
| ev_src_err | input | NCH | Per-channel source error pulses |
| ev_dst_err | input | NCH | Per-channel destination error pulses |
| ev_cfg_err | input | NCH | Per-channel configuration error pulses |
| ch_ie | input | 2*NCH | Per-channel enable pair: bit 2i gates done, bit 2i+1 gates errors |
| ch_busy | input | NCH | Per-channel busy flags, readable at 0x820 |
| irq | output | 1 | Combined interrupt |

## Verification
An event pulse or clearing write driven before clock edge k is visible in the raw and masked state, and on irq, after edge k. The bench therefore drives on the falling edge, waits one rising edge and compares on the next falling edge. A change of ch_ie moves irq with no clock edge in between, so irq is compared in the same half cycle. Read data is due exactly one cycle after the read strobe's edge. The bench compares bus_rdata and bus_rvalid on the falling edge after that edge, against a model whose state is frozen at the strobe.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int NUM_CLASSES = 4;

    typedef enum logic [1:0] {
        CLS_DONE = 2'd0,
        CLS_SERR = 2'd1,
        CLS_DERR = 2'd2,
        CLS_CFG  = 2'd3
    } evt_class_e;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_MASKED = 2'd1,
        HIT_RAW    = 2'd2,
        HIT_BUSY   = 2'd3
    } reg_hit_e;

    typedef struct packed {
        reg_hit_e   hit;
        evt_class_e cls;
    } reg_dec_t;

    typedef enum logic [0:0] {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

    localparam logic [11:0] OFS_MASKED_BASE = 12'h800;
    localparam logic [11:0] OFS_RAW_BASE    = 12'h810;
    localparam logic [11:0] OFS_BUSY        = 12'h820;

    function automatic reg_dec_t decode_ofs(input logic [11:0] ofs);
        reg_dec_t d;
        d.hit = HIT_NONE;
        d.cls = evt_class_e'(ofs[3:2]);
        if (ofs[1:0] == 2'b00) begin
            if (ofs[11:4] == OFS_MASKED_BASE[11:4]) begin
                d.hit = HIT_MASKED;
            end else if (ofs[11:4] == OFS_RAW_BASE[11:4]) begin
                d.hit = HIT_RAW;
            end else if (ofs == OFS_BUSY) begin
                d.hit = HIT_BUSY;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_class_bank.sv
module irq_class_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_bits,
    input  logic [NCH-1:0] en,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] masked
);

    logic [NCH-1:0] clr_eff;
    logic [NCH-1:0] raw_next;

    assign clr_eff = clr_we ? clr_bits : '0;

    // event is ORed after the clear so it wins a same-cycle collision
    always_comb begin
        raw_next = (raw & ~clr_eff) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw <= '0;
        end else begin
            raw <= raw_next;
        end
    end

    assign masked = raw & en;

    // R2: a raw bit only rises because of an event pulse
    a_r2_set_only_by_event: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & ~$past(raw) & ~$past(evt)) == '0));

    // R2: a bit stays set when no clearing write is present
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((raw & $past(raw)) == $past(raw)));

    // R3: written ones clear, unless an event hits the same bit
    a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw & $past(clr_bits) & ~$past(evt)) == '0));

    // R4: a pulsed bit is set after the edge regardless of clears
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw & $past(evt)) == $past(evt)));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_status_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic                              bus_rvalid,
    input  logic [NUM_CLASSES-1:0][NCH-1:0]   raw_vec,
    input  logic [NUM_CLASSES-1:0][NCH-1:0]   masked_vec,
    input  logic [NCH-1:0]                    busy_vec,
    output logic [NUM_CLASSES-1:0]            clr_we,
    output logic [NCH-1:0]                    clr_bits
);

    localparam int PAD_W = DATA_W - NCH;

    port_state_e    state_q;
    port_state_e    state_d;
    reg_dec_t       dec;
    logic           rd_req;
    logic           wr_req;
    logic [NCH-1:0] rd_vec;
    logic [DATA_W-1:0] rdata_q;

    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel && bus_wr;

    always_comb begin
        if (bus_addr[ADDR_W-1:12] == '0) begin
            dec = decode_ofs(bus_addr[11:0]);
        end else begin
            dec = '{hit: HIT_NONE, cls: CLS_DONE};
        end
    end

    // one clear strobe per class, from a raw-register write
    genvar gc;
    generate
        for (gc = 0; gc < NUM_CLASSES; gc++) begin : g_clr
            assign clr_we[gc] = wr_req && (dec.hit == HIT_RAW) &&
                                (dec.cls == evt_class_e'(gc));
        end
    endgenerate
    assign clr_bits = bus_wdata[NCH-1:0];

    always_comb begin
        unique case (dec.hit)
            HIT_MASKED: rd_vec = masked_vec[dec.cls];
            HIT_RAW:    rd_vec = raw_vec[dec.cls];
            HIT_BUSY:   rd_vec = busy_vec;
            HIT_NONE:   rd_vec = '0;
            default:    rd_vec = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (rd_req) state_d = PORT_RESP;
            PORT_RESP: if (!rd_req) state_d = PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= {{PAD_W{1'b0}}, rd_vec};
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == PORT_RESP);

    // R8: every read strobe is answered in the following cycle
    a_r8_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    // R8: no response without a read strobe one cycle earlier
    a_r8_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req) |=> !bus_rvalid);

    // R9: a write that misses the raw registers raises no clear strobe
    a_r9_clear_only_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && dec.hit != HIT_RAW) |-> (clr_we == '0));

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    input  logic [NCH-1:0]     ev_done,
    input  logic [NCH-1:0]     ev_src_err,
    input  logic [NCH-1:0]     ev_dst_err,
    input  logic [NCH-1:0]     ev_cfg_err,
    input  logic [2*NCH-1:0]   ch_ie,
    input  logic [NCH-1:0]     ch_busy,
    output logic               irq
);

    logic [NUM_CLASSES-1:0][NCH-1:0] evt_vec;
    logic [NUM_CLASSES-1:0][NCH-1:0] en_vec;
    logic [NUM_CLASSES-1:0][NCH-1:0] raw_vec;
    logic [NUM_CLASSES-1:0][NCH-1:0] masked_vec;
    logic [NUM_CLASSES-1:0]          clr_we;
    logic [NCH-1:0]                  clr_bits;
    logic [NCH-1:0]                  en_done;
    logic [NCH-1:0]                  en_err;

    assign evt_vec[CLS_DONE] = ev_done;
    assign evt_vec[CLS_SERR] = ev_src_err;
    assign evt_vec[CLS_DERR] = ev_dst_err;
    assign evt_vec[CLS_CFG]  = ev_cfg_err;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_en
            assign en_done[gi] = ch_ie[2*gi];
            assign en_err[gi]  = ch_ie[2*gi+1];
        end
    endgenerate

    assign en_vec[CLS_DONE] = en_done;
    assign en_vec[CLS_SERR] = en_err;
    assign en_vec[CLS_DERR] = en_err;
    assign en_vec[CLS_CFG]  = en_err;

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CLASSES; gc++) begin : g_bank
            irq_class_bank #(.NCH(NCH)) i_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (evt_vec[gc]),
                .clr_we   (clr_we[gc]),
                .clr_bits (clr_bits),
                .en       (en_vec[gc]),
                .raw      (raw_vec[gc]),
                .masked   (masked_vec[gc])
            );
        end
    endgenerate

    irq_reg_port #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .raw_vec    (raw_vec),
        .masked_vec (masked_vec),
        .busy_vec   (ch_busy),
        .clr_we     (clr_we),
        .clr_bits   (clr_bits)
    );

    assign irq = |masked_vec;

    // R6: with every enable low the line stays quiet
    a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ie == '0) |-> !irq);

    // R6: a done pulse on an enabled channel raises the line next cycle
    a_r6_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_done & en_done) != '0 && $stable(ch_ie)) |=> irq);

endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [NCH-1:0] ev_done = '0, ev_src_err = '0, ev_dst_err = '0, ev_cfg_err = '0;
    logic [2*NCH-1:0] ch_ie = '0;
    logic [NCH-1:0] ch_busy = '0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;
    logic [NCH-1:0] m_raw [4];

    always #2 clk = ~clk;

    irq_status_unit #(.NCH(NCH)) i_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ev_done(ev_done), .ev_src_err(ev_src_err),
        .ev_dst_err(ev_dst_err), .ev_cfg_err(ev_cfg_err), .ch_ie(ch_ie),
        .ch_busy(ch_busy), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] en_of(input int c);
        logic [NCH-1:0] e;
        for (int i = 0; i < NCH; i++) e[i] = (c == 0) ? ch_ie[2*i] : ch_ie[2*i+1];
        return e;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int c = 0; c < 4; c++) r |= |(m_raw[c] & en_of(c));
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] v = '0;
        if (a >= 12'h800 && a <= 12'h80C && a[1:0] == 2'b00)
            v[NCH-1:0] = m_raw[a[3:2]] & en_of(int'(a[3:2]));
        else if (a >= 12'h810 && a <= 12'h81C && a[1:0] == 2'b00)
            v[NCH-1:0] = m_raw[a[3:2]];
        else if (a == 12'h820)
            v[NCH-1:0] = ch_busy;
        return v;
    endfunction

    // one cycle with events and an optional raw-register write; called at negedge
    task automatic step(input logic [NCH-1:0] e0, e1, e2, e3,
                        input bit do_wr, input logic [11:0] a, input logic [31:0] d);
        ev_done = e0; ev_src_err = e1; ev_dst_err = e2; ev_cfg_err = e3;
        bus_sel = do_wr; bus_wr = do_wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        ev_done = '0; ev_src_err = '0; ev_dst_err = '0; ev_cfg_err = '0;
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (do_wr && a >= 12'h810 && a <= 12'h81C && a[1:0] == 2'b00)
            m_raw[a[3:2]] &= ~d[NCH-1:0];
        m_raw[0] |= e0; m_raw[1] |= e1; m_raw[2] |= e2; m_raw[3] |= e3;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        logic [31:0] e;
        e = exp_read(a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        chk({tag, " rvalid"}, {31'b0, bus_rvalid}, 32'd1);
        chk({tag, " rdata"}, bus_rdata, e);
    endtask

    task automatic all_raw(input string tag);
        for (int c = 0; c < 4; c++) rd(12'h810 + 12'(4*c), tag);
    endtask

    initial begin
        logic [31:0] e_a, e_b;
        void'($urandom(32'h1c0ffee5));
        for (int c = 0; c < 4; c++) m_raw[c] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk("R1 irq in reset", {31'b0, irq}, 32'd0);
        chk("R1 rvalid in reset", {31'b0, bus_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        all_raw("R1 raw after reset");

        // R2: single done event, enable off then on
        step(8'h04, 0, 0, 0, 0, 0, 0);
        rd(12'h810, "R2 done raw set");
        chk("R6 irq off when disabled", {31'b0, irq}, 32'd0);
        ch_ie = 16'h0010;            // done enable for channel 2
        #0.5;
        chk("R6 irq follows enable", {31'b0, irq}, {31'b0, exp_irq()});
        rd(12'h800, "R5 masked done");
        step(0, 0, 0, 0, 0, 0, 0);
        rd(12'h810, "R2 bit sticky");

        // R5: error classes use the high enable bit
        step(0, 8'h81, 8'h02, 8'h40, 0, 0, 0);
        ch_ie = 16'h8002;            // err en ch7, err en ch0
        rd(12'h804, "R5 masked src");
        rd(12'h808, "R5 masked dst");
        rd(12'h80C, "R5 masked cfg");

        // R3: zero write no effect, ones clear
        step(0, 0, 0, 0, 1, 12'h814, 32'h0);
        rd(12'h814, "R3 zero write keeps");
        step(0, 0, 0, 0, 1, 12'h814, 32'h01);
        rd(12'h814, "R3 clear bit0");

        // R4: event and clear collide
        step(8'h08, 0, 0, 0, 1, 12'h810, 32'h08);
        rd(12'h810, "R4 event wins");

        // R9: writes outside raw registers
        step(0, 0, 0, 0, 1, 12'h800, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, 12'h820, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, 12'h830, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, 12'h811, 32'hFFFF_FFFF);
        all_raw("R9 no effect");

        // R3: all ones clears every class
        for (int c = 0; c < 4; c++) step(0, 0, 0, 0, 1, 12'h810 + 12'(4*c), 32'hFFFF_FFFF);
        all_raw("R3 all ones");
        chk("R6 irq clear", {31'b0, irq}, 32'd0);

        // R7 / R8
        ch_busy = 8'hA5;
        rd(12'h820, "R7 busy");
        rd(12'h7FC, "R8 unmapped");
        @(negedge clk);
        chk("R8 rvalid drops", {31'b0, bus_rvalid}, 32'd0);

        // R10: back-to-back reads
        step(8'h11, 0, 0, 8'h22, 0, 0, 0);
        e_a = exp_read(12'h810);
        e_b = exp_read(12'h81C);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h810;
        @(posedge clk); @(negedge clk);
        bus_addr = 12'h81C;
        chk("R10 first data", bus_rdata, e_a);
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        chk("R10 rvalid held", {31'b0, bus_rvalid}, 32'd1);
        chk("R10 second data", bus_rdata, e_b);

        // random mix: R2 R3 R4 R5 R6
        for (int k = 0; k < 400; k++) begin
            logic [NCH-1:0] r0, r1, r2, r3;
            bit w;
            int cl;
            r0 = NCH'($urandom) & NCH'($urandom);
            r1 = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            r2 = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            r3 = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            w  = ($urandom % 2) == 0;
            cl = int'($urandom % 4);
            if (($urandom % 8) == 0) ch_ie = 16'($urandom);
            step(r0, r1, r2, r3, w, 12'h810 + 12'(4*cl), $urandom);
            chk("R6 irq random", {31'b0, irq}, {31'b0, exp_irq()});
            if ((k % 4) == 0) rd(12'h810 + 12'(4*($urandom % 4)), "R2 R3 raw random");
            if ((k % 4) == 2) rd(12'h800 + 12'(4*($urandom % 4)), "R5 masked random");
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

endmodule